// File: doc/BRIEF.md
# Decimated Waveform Sampler with New-Sample Interrupt

This block taps the sample streams of two metering channels and lets a host microcontroller read raw waveform data without taking anything away from the power and energy datapaths that consume the same streams. Each stream is a series of signed 24-bit two's complement words, each marked by a one-cycle valid strobe. The nominal rate is one word every 128 clocks. The block only observes these strobes and has no way to stall or back-pressure either stream.

A two-bit source code picks the stream to capture, or turns capture off. A two-bit rate code sets how many of the selected samples are discarded between captures. Each kept sample replaces the whole content of a readable waveform register. The same cycle also sets a new-sample flag. When the sample interrupt is enabled, that flag drives an active-low interrupt request. The host clears the flag with a one-cycle read-reset strobe.

Top module: `wave_capture`

## Requirements
- R1: A synchronous active-high `rst` clears `wave_data` to 0, clears `new_smp`, and clears the decimation counter. While `rst` is high and after it falls, `irq_n` is 1.
- R2: The rate code `rate_sel` sets the decimation. Codes 00, 01, 10 and 11 keep every 1st, 2nd, 4th and 8th sample of the selected stream. The first selected sample after the counter is cleared is always kept.
- R3: In a cycle where `rate_wr` is 1, the decimation counter is cleared. Any selected sample in that same cycle is dropped, so the next selected sample is kept.
- R4: Source code `src_sel` = 2'b10 selects channel 1 (`ch1_valid`/`ch1_data`). Codes 2'b01 and 2'b11 select channel 2 (`ch2_valid`/`ch2_data`).
- R5: With `src_sel` = 2'b00, no sample is captured, `new_smp` is never set, `wave_data` holds its value, and the decimation counter holds its count.
- R6: On the clock edge that accepts a kept sample, `wave_data` takes all 24 bits of that sample. It is visible from the next cycle and holds until the next kept sample.
- R7: `new_smp` is set by each kept sample and cleared by a one-cycle `stat_rd_clr` strobe. When a set and a clear fall in the same cycle, the flag ends up set.
- R8: `irq_n` is 0 exactly while `new_smp` and `smp_irq_en` are both 1. With `smp_irq_en` at 0, the flag still sets but `irq_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch1_valid | input | 1 | Channel 1 sample strobe |
| ch1_data | input | 24 | Channel 1 sample, two's complement |
| ch2_valid | input | 1 | Channel 2 sample strobe |
| ch2_data | input | 24 | Channel 2 sample, two's complement |
| rate_sel | input | 2 | Decimation code |
| rate_wr | input | 1 | Rate code write strobe; clears the counter |
| src_sel | input | 2 | Source code: 00 off, 10 channel 1, 01/11 channel 2 |
| smp_irq_en | input | 1 | New-sample interrupt enable |
| stat_rd_clr | input | 1 | Read-reset strobe for the new-sample flag |
| wave_data | output | 24 | Last captured sample |
| new_smp | output | 1 | New-sample status flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A decimation counter in the wrong state moves which samples are kept. This shows at the ports within one output period, at most eight selected samples: the flag rises on the wrong strobe, and the scoreboard pops a value that does not match. A bad source mux or a bad capture register shows as a wrong `wave_data` in the cycle after the first kept sample. A stuck or wrongly prioritised flag shows on `new_smp` and `irq_n` in the cycle after the set, the clear, or the colliding strobes.

// File: rtl/wave_capture.sv
module wave_capture #(
  parameter int DW = 24,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ch1_valid,
  input  logic [DW-1:0] ch1_data,
  input  logic          ch2_valid,
  input  logic [DW-1:0] ch2_data,
  input  logic [RW-1:0] rate_sel,
  input  logic          rate_wr,
  input  logic [1:0]    src_sel,
  input  logic          smp_irq_en,
  input  logic          stat_rd_clr,
  output logic [DW-1:0] wave_data,
  output logic          new_smp,
  output logic          irq_n
);
  localparam int CW = (1 << RW) - 1;

  logic [CW-1:0] cnt, mask;
  logic          sel_valid, keep;
  logic [DW-1:0] sel_data;

  assign sel_valid = (src_sel == 2'b10) ? ch1_valid :
                     (src_sel == 2'b00) ? 1'b0 : ch2_valid;
  assign sel_data  = (src_sel == 2'b10) ? ch1_data : ch2_data;
  assign mask      = CW'((1 << rate_sel) - 1);
  assign keep      = sel_valid && !rate_wr && ((cnt & mask) == '0);
  assign irq_n     = !(new_smp && smp_irq_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      wave_data <= '0;
      new_smp   <= 1'b0;
    end else begin
      if (rate_wr)        cnt <= '0;
      else if (sel_valid) cnt <= cnt + 1'b1;
      if (keep) wave_data <= sel_data;
      if (keep)             new_smp <= 1'b1;
      else if (stat_rd_clr) new_smp <= 1'b0;
    end
  end
endmodule

module wave_capture_chk #(
  parameter int DW = 24,
  parameter int RW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ch1_valid,
  input logic [DW-1:0] ch1_data,
  input logic          ch2_valid,
  input logic [DW-1:0] ch2_data,
  input logic [RW-1:0] rate_sel,
  input logic          rate_wr,
  input logic [1:0]    src_sel,
  input logic          smp_irq_en,
  input logic          stat_rd_clr,
  input logic [DW-1:0] wave_data,
  input logic          new_smp,
  input logic          irq_n
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (irq_n && !new_smp && wave_data == '0));

  a_r5_off_no_flag: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'b00 && !new_smp) |=> !new_smp);

  a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    (!ch1_valid && !ch2_valid) |=> $stable(wave_data));

  a_r4_ch1_full_rate: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'b10 && rate_sel == '0 && ch1_valid && !rate_wr)
      |=> (new_smp && wave_data == $past(ch1_data)));

  a_r7_clear_works: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_clr && !ch1_valid && !ch2_valid) |=> !new_smp);

  a_r8_no_irq_without_flag: assert property (@(posedge clk) disable iff (rst)
    !new_smp |-> irq_n);
endmodule

bind wave_capture wave_capture_chk #(.DW(DW), .RW(RW)) chk_i (.*);

// File: tb/wave_capture_tb_top.sv
module wave_capture_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        ch1_valid = 0, ch2_valid = 0, rate_wr = 0, smp_irq_en = 0, stat_rd_clr = 0;
  logic [23:0] ch1_data = 0, ch2_data = 0;
  logic [1:0]  rate_sel = 0, src_sel = 2'b10;
  logic [23:0] wave_data;
  logic        new_smp, irq_n;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [23:0] exp_q[$];
  int mcnt = 0;
  bit mflag = 0;
  logic [23:0] mwave = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_capture dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit prev_flag = 0;
  always @(negedge clk) begin
    if (rst) prev_flag = 0;
    else begin
      if (new_smp && !prev_flag) begin
        if (exp_q.size() == 0) check(0, "R6 scoreboard unexpected", wave_data, 0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          check(wave_data == e, "R6 scoreboard", wave_data, e);
        end
      end
      prev_flag = new_smp;
    end
  end

  // called just after a negedge; drives one cycle
  task automatic step(input bit v1, input bit v2, input logic [23:0] d1, input logic [23:0] d2,
                      input bit wr, input bit clr);
    bit sv, keep;
    logic [23:0] sd;
    ch1_valid = v1; ch2_valid = v2; ch1_data = d1; ch2_data = d2; rate_wr = wr; stat_rd_clr = clr;
    sv = (src_sel == 2'b10) ? v1 : (src_sel == 2'b00) ? 1'b0 : v2;
    sd = (src_sel == 2'b10) ? d1 : d2;
    keep = sv && !wr && ((mcnt % (1 << rate_sel)) == 0);
    if (wr) mcnt = 0; else if (sv) mcnt = (mcnt + 1) % 8;
    if (keep) begin
      if (!mflag) exp_q.push_back(sd);
      mwave = sd;
    end
    mflag = keep ? 1'b1 : (clr ? 1'b0 : mflag);
    @(negedge clk);
    ch1_valid = 0; ch2_valid = 0; rate_wr = 0; stat_rd_clr = 0;
    check(new_smp == mflag, "R7 flag", new_smp, mflag);
    check(wave_data == mwave, "R6 wave", wave_data, mwave);
    check(irq_n == !(mflag && smp_irq_en), "R8 irq", irq_n, !(mflag && smp_irq_en));
  endtask

  task automatic idle_clr();
    step(0, 0, 0, 0, 0, 1);
  endtask

  task automatic samp(input logic [23:0] d1, input logic [23:0] d2);
    step(1, 1, d1, d2, 0, 0);
    idle_clr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(irq_n === 1'b1, "R1 irq in reset", irq_n, 1);
    rst = 0;
    @(negedge clk);
    check(wave_data === 24'h0, "R1 wave reset", wave_data, 0);
    check(new_smp === 1'b0, "R1 flag reset", new_smp, 0);
    check(irq_n === 1'b1, "R1 irq after reset", irq_n, 1);

    smp_irq_en = 1;
    src_sel = 2'b10;
    samp(24'h2851EC, 24'h111111);               // R4 channel 1
    samp(24'hD7AE14, 24'h222222);
    src_sel = 2'b01;
    samp(24'h333333, 24'hABCDEF);               // R4 channel 2
    src_sel = 2'b11;
    samp(24'h444444, 24'h800000);

    for (int r = 1; r < 4; r++) begin           // R2 decimation by 2, 4, 8
      rate_sel = r[1:0];
      step(0, 0, 0, 0, 1, 0);
      for (int k = 0; k < 10; k++) samp(24'h010000 * r + k, 24'h100000 + 24'h1000 * r + k);
    end

    rate_sel = 2'b01;                           // R3 write collides with a sample
    step(0, 0, 0, 0, 1, 0);
    samp(24'h0, 24'h5A5A01);
    step(1, 1, 0, 24'h5A5A02, 1, 0);
    check(wave_data == 24'h5A5A01, "R3 dropped on write", wave_data, 24'h5A5A01);
    samp(24'h0, 24'h5A5A03);
    check(wave_data == 24'h5A5A03, "R3 next kept", wave_data, 24'h5A5A03);

    rate_sel = 2'b00;
    step(0, 0, 0, 0, 1, 0);
    src_sel = 2'b00;                            // R5 capture off
    samp(24'h777777, 24'h888888);
    check(new_smp == 1'b0, "R5 no flag", new_smp, 0);
    check(wave_data == 24'h5A5A03, "R5 hold", wave_data, 24'h5A5A03);

    src_sel = 2'b10;                            // R7 set beats clear
    step(1, 0, 24'h0F0F0F, 0, 0, 1);
    check(new_smp == 1'b1, "R7 set wins from clear", new_smp, 1);
    step(1, 0, 24'h0E0E0E, 0, 0, 1);
    check(new_smp == 1'b1, "R7 set wins while set", new_smp, 1);
    check(wave_data == 24'h0E0E0E, "R6 overwrite while set", wave_data, 24'h0E0E0E);
    smp_irq_en = 0;                             // R8 disabled interrupt
    #1 check(irq_n == 1'b1, "R8 enable off", irq_n, 1);
    idle_clr();
    samp(24'h123456, 0);
    step(1, 0, 24'h654321, 0, 0, 0);
    check(irq_n == 1'b1 && new_smp, "R8 flag set irq high", {irq_n, new_smp}, 2'b11);
    smp_irq_en = 1;
    #1 check(irq_n == 1'b0, "R8 enable on", irq_n, 0);
    idle_clr();
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule